// File: doc/BRIEF.md
# DMA Descriptor Table Dispatcher

This block sits in a memory-to-host DMA path between host software and two data-mover engines. Software starts a transfer by writing one pointer descriptor. That descriptor names where a descriptor table sits in system memory and how many entries the table holds. The block turns the pointer into a single table-fetch request to a read mover. It then collects the descriptors that the read mover returns in an internal queue of 16 entries.

Queued descriptors go out to a write mover one at a time and in arrival order. Each descriptor is offered on either the normal channel or the priority channel, chosen by a flag bit inside it, and leaves the queue only when that channel's ready is high. The table ends with an immediate-data descriptor, whose dispatch posts the completion word to host memory. When that descriptor is dispatched, the block leaves its busy state and accepts the next pointer. Every descriptor is 512 bits wide.

Top module: `dma_table_dispatcher`

## Requirements
- R1: A pointer descriptor carries the table address in bits [63:0] and the entry count in bits [79:64]. It is accepted in a cycle where `sw_desc_valid` and `sw_desc_ready` are both high, and `sw_desc_ready` is high exactly when `busy` is low.
- R2: After a pointer is accepted, `rd_req_valid` rises with `rd_req_addr` equal to the table address and `rd_req_bytes` equal to count × 64. Both values stay unchanged until the cycle in which `rd_req_ready` is high. Exactly one request is made per pointer.
- R3: The fetch request is withheld while the number of free queue slots (16 minus occupancy) is below the entry count. It appears in the cycle after enough room is freed. The count must not exceed 16.
- R4: Each `rd_rsp_valid` cycle stores `rd_rsp_data` in the queue. Descriptors leave in the order they arrived, and none is lost.
- R5: The oldest queued descriptor drives `wr_desc_data`. If its bit 511 is 1 it is offered only on `wr_prio_valid`; if that bit is 0 it is offered only on `wr_norm_valid`. Both valids are low when the queue is empty.
- R6: The oldest descriptor is removed only in a cycle where its channel's valid and ready are both high. A ready on the other channel has no effect, so a stalled oldest entry blocks everything behind it.
- R7: `busy` rises in the cycle after a pointer is accepted. It stays high through the cycle in which a descriptor with bit 510 set (immediate write) is dispatched, and is low the cycle after. A pointer offered while busy is not taken and produces no fetch.
- R8: A synchronous active-high `rst` empties the queue, clears `busy` and any pending fetch, and leaves `rd_req_valid`, `wr_norm_valid` and `wr_prio_valid` low from the next cycle.
- R9: When a descriptor arrives in the same cycle that another is dispatched, both take effect. Occupancy is unchanged, and the new entry keeps its place at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_desc_valid | input | 1 | Software offers a pointer descriptor |
| sw_desc_ready | output | 1 | Block can take a pointer descriptor |
| sw_desc_data | input | 512 | Pointer descriptor (address, count) |
| rd_req_valid | output | 1 | Table-fetch request to the read mover |
| rd_req_ready | input | 1 | Read mover takes the request |
| rd_req_addr | output | 64 | System-memory address of the table |
| rd_req_bytes | output | 22 | Table length in bytes |
| rd_rsp_valid | input | 1 | Read mover returns one table descriptor |
| rd_rsp_data | input | 512 | Returned descriptor |
| wr_norm_valid | output | 1 | Oldest descriptor offered on the normal channel |
| wr_norm_ready | input | 1 | Write mover ready for a normal descriptor |
| wr_prio_valid | output | 1 | Oldest descriptor offered on the priority channel |
| wr_prio_ready | input | 1 | Write mover ready for a priority descriptor |
| wr_desc_data | output | 512 | Oldest descriptor |
| busy | output | 1 | A table transfer is in progress |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a returned descriptor and a dispatch: the bench pushes a tagged descriptor while raising normal-ready on a queue two slots short of full. It then judges the result by the fetch gate, which must stay closed because occupancy is unchanged, and by the tag order seen at the output afterwards. The second pair is the dispatch of the immediate descriptor and a new pointer offered in that same cycle. There the bench requires that ready was low, that busy falls one cycle later, and that no fetch request follows.

// File: rtl/dma_table_dispatcher.sv
module dma_table_dispatcher #(
  parameter int DESC_W   = 512,
  parameter int ADDR_W   = 64,
  parameter int CNT_W    = 16,
  parameter int DEPTH    = 16,
  parameter int PRIO_BIT = 511,
  parameter int IMM_BIT  = 510
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sw_desc_valid,
  output logic                           sw_desc_ready,
  input  logic [DESC_W-1:0]              sw_desc_data,
  output logic                           rd_req_valid,
  input  logic                           rd_req_ready,
  output logic [ADDR_W-1:0]              rd_req_addr,
  output logic [CNT_W+$clog2(DESC_W/8)-1:0] rd_req_bytes,
  input  logic                           rd_rsp_valid,
  input  logic [DESC_W-1:0]              rd_rsp_data,
  output logic                           wr_norm_valid,
  input  logic                           wr_norm_ready,
  output logic                           wr_prio_valid,
  input  logic                           wr_prio_ready,
  output logic [DESC_W-1:0]              wr_desc_data,
  output logic                           busy
);

  localparam int SHIFT   = $clog2(DESC_W/8);
  localparam int BYTES_W = CNT_W + SHIFT;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int OCC_W   = PTR_W + 1;

  logic              busy_q, pend_q;
  logic [ADDR_W-1:0] tab_addr;
  logic [CNT_W-1:0]  tab_cnt;
  logic [DESC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [OCC_W-1:0]  occ;

  wire unused_sw_bits = ^sw_desc_data[DESC_W-1:ADDR_W+CNT_W];

  wire              empty  = (occ == '0);
  wire              full   = (occ == OCC_W'(DEPTH));
  wire [OCC_W-1:0]  free   = OCC_W'(DEPTH) - occ;
  wire              room   = CNT_W'(free) >= tab_cnt;
  wire              accept = sw_desc_valid && !busy_q;

  assign wr_desc_data  = mem[rp];
  assign wr_norm_valid = !empty && !wr_desc_data[PRIO_BIT];
  assign wr_prio_valid = !empty &&  wr_desc_data[PRIO_BIT];

  wire pop  = (wr_norm_valid && wr_norm_ready) || (wr_prio_valid && wr_prio_ready);
  wire push = rd_rsp_valid && (!full || pop);

  assign sw_desc_ready = !busy_q;
  assign busy          = busy_q;
  assign rd_req_valid  = pend_q && room;
  assign rd_req_addr   = tab_addr;
  assign rd_req_bytes  = BYTES_W'(tab_cnt) << SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      tab_addr <= '0;
      tab_cnt  <= '0;
      wp       <= '0;
      rp       <= '0;
      occ      <= '0;
    end else begin
      if (accept) begin
        busy_q   <= 1'b1;
        pend_q   <= 1'b1;
        tab_addr <= sw_desc_data[ADDR_W-1:0];
        tab_cnt  <= sw_desc_data[ADDR_W +: CNT_W];
      end else begin
        if (pop && wr_desc_data[IMM_BIT]) busy_q <= 1'b0;
        if (rd_req_valid && rd_req_ready) pend_q <= 1'b0;
      end
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      occ <= occ + OCC_W'(push) - OCC_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rd_rsp_data;
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    rd_rsp_valid && full |-> pop);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_bytes));

  a_r6_head_hold: assert property (@(posedge clk) disable iff (rst)
    wr_norm_valid && !wr_norm_ready |=> wr_norm_valid && $stable(wr_desc_data));

  a_r6_prio_hold: assert property (@(posedge clk) disable iff (rst)
    wr_prio_valid && !wr_prio_ready |=> wr_prio_valid && $stable(wr_desc_data));

  a_r7_busy_rise: assert property (@(posedge clk) disable iff (rst)
    sw_desc_valid && sw_desc_ready |=> busy && !sw_desc_ready);

  a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
    busy && !(pop && wr_desc_data[IMM_BIT]) |=> busy);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !busy && !rd_req_valid && !wr_norm_valid && !wr_prio_valid);

endmodule

// File: tb/dma_table_dispatcher_test.sv
module dma_table_dispatcher_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst, sw_desc_valid, sw_desc_ready, rd_req_valid, rd_req_ready;
  logic [511:0] sw_desc_data, rd_rsp_data, wr_desc_data;
  logic [63:0]  rd_req_addr;
  logic [21:0]  rd_req_bytes;
  logic         rd_rsp_valid, wr_norm_valid, wr_norm_ready, wr_prio_valid, wr_prio_ready, busy;

  dma_table_dispatcher uut (
    .clk(clk), .rst(rst),
    .sw_desc_valid(sw_desc_valid), .sw_desc_ready(sw_desc_ready), .sw_desc_data(sw_desc_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_bytes(rd_req_bytes),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_norm_valid(wr_norm_valid), .wr_norm_ready(wr_norm_ready),
    .wr_prio_valid(wr_prio_valid), .wr_prio_ready(wr_prio_ready),
    .wr_desc_data(wr_desc_data), .busy(busy)
  );

  // {prio, imm, tag}
  localparam logic [33:0] TBL [4] = '{34'h0_000000A1, 34'h2_000000B2, 34'h2_000000C3, 34'h1_000000D4};

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  function automatic logic [511:0] mk(input logic p, input logic im, input logic [31:0] tag);
    logic [511:0] d = '0;
    d[511] = p; d[510] = im; d[31:0] = tag;
    return d;
  endfunction

  function automatic logic [511:0] ptr(input logic [63:0] a, input logic [15:0] c);
    logic [511:0] d = '0;
    d[63:0] = a; d[79:64] = c;
    return d;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; sw_desc_valid = 0; sw_desc_data = '0; rd_req_ready = 0;
    rd_rsp_valid = 0; rd_rsp_data = '0; wr_norm_ready = 0; wr_prio_ready = 0;
    tick(); tick();
    chk("R8 ready after reset", 64'(sw_desc_ready), 1);
    chk("R8 busy after reset", 64'(busy), 0);
    chk("R8 req after reset", 64'(rd_req_valid), 0);
    chk("R8 valids after reset", 64'({wr_norm_valid, wr_prio_valid}), 0);
    rst = 0;
    tick();

    // table walk
    sw_desc_data = ptr(64'h1234_5678_9ABC_DEF0, 16'd4); sw_desc_valid = 1;
    chk("R1 ready while idle", 64'(sw_desc_ready), 1);
    tick();
    sw_desc_valid = 0;
    chk("R7 busy after accept", 64'(busy), 1);
    chk("R7 ready low while busy", 64'(sw_desc_ready), 0);
    chk("R2 fetch raised", 64'(rd_req_valid), 1);
    chk("R1 fetch address", rd_req_addr, 64'h1234_5678_9ABC_DEF0);
    chk("R2 fetch bytes", 64'(rd_req_bytes), 256);
    tick(); tick();
    chk("R2 fetch held", 64'(rd_req_valid), 1);
    chk("R2 address held", rd_req_addr, 64'h1234_5678_9ABC_DEF0);
    rd_req_ready = 1; tick(); rd_req_ready = 0;
    chk("R2 single request", 64'(rd_req_valid), 0);
    for (int i = 0; i < 4; i++) begin
      rd_rsp_valid = 1; rd_rsp_data = mk(TBL[i][33], TBL[i][32], TBL[i][31:0]);
      tick();
    end
    rd_rsp_valid = 0;
    for (int i = 0; i < 4; i++) begin
      logic p, im;
      p = TBL[i][33]; im = TBL[i][32];
      chk("R4 head order", 64'(wr_desc_data[31:0]), 64'(TBL[i][31:0]));
      chk("R5 channel select", 64'({wr_prio_valid, wr_norm_valid}), p ? 2 : 1);
      wr_norm_ready = p; wr_prio_ready = !p;
      tick();
      chk("R6 wrong ready ignored", 64'(wr_desc_data[31:0]), 64'(TBL[i][31:0]));
      chk("R6 still offered", 64'(wr_norm_valid | wr_prio_valid), 1);
      wr_norm_ready = !p; wr_prio_ready = p;
      if (im) begin
        sw_desc_data = ptr(64'hDEAD_0000, 16'd1); sw_desc_valid = 1;
        chk("R7 refused during last dispatch", 64'(sw_desc_ready), 0);
      end
      chk("R7 busy before last", 64'(busy), 1);
      tick();
      wr_norm_ready = 0; wr_prio_ready = 0; sw_desc_valid = 0;
      if (im) begin
        chk("R7 busy cleared", 64'(busy), 0);
        chk("R7 refused pointer no fetch", 64'(rd_req_valid), 0);
      end
    end
    chk("R5 empty no valids", 64'({wr_norm_valid, wr_prio_valid}), 0);

    // room gating and simultaneous push/pop
    for (int i = 0; i < 14; i++) begin
      rd_rsp_valid = 1; rd_rsp_data = mk(0, 0, 32'h100 + i); tick();
    end
    rd_rsp_valid = 0;
    sw_desc_data = ptr(64'h40, 16'd4); sw_desc_valid = 1; tick(); sw_desc_valid = 0;
    chk("R7 busy second table", 64'(busy), 1);
    chk("R3 withheld free 2", 64'(rd_req_valid), 0);
    rd_rsp_valid = 1; rd_rsp_data = mk(0, 0, 32'h200); wr_norm_ready = 1; tick();
    rd_rsp_valid = 0; wr_norm_ready = 0;
    chk("R9 occupancy kept", 64'(rd_req_valid), 0);
    chk("R9 head advanced", 64'(wr_desc_data[31:0]), 64'h101);
    wr_norm_ready = 1; tick(); wr_norm_ready = 0;
    chk("R3 withheld free 3", 64'(rd_req_valid), 0);
    wr_norm_ready = 1; tick(); wr_norm_ready = 0;
    chk("R3 released free 4", 64'(rd_req_valid), 1);
    chk("R3 bytes", 64'(rd_req_bytes), 256);
    chk("R1 address second", rd_req_addr, 64'h40);
    rd_req_ready = 1; tick(); rd_req_ready = 0;
    for (int k = 0; k < 12; k++) begin
      chk("R4 drain order", 64'(wr_desc_data[31:0]), (k < 11) ? 64'(32'h103 + k) : 64'h200);
      wr_norm_ready = 1; tick(); wr_norm_ready = 0;
    end
    chk("R4 drained", 64'(wr_norm_valid), 0);
    rd_rsp_valid = 1; rd_rsp_data = mk(1, 1, 32'hE0); tick(); rd_rsp_valid = 0;
    chk("R5 prio immediate", 64'(wr_prio_valid), 1);
    chk("R7 busy held", 64'(busy), 1);
    wr_prio_ready = 1; tick(); wr_prio_ready = 0;
    chk("R7 busy cleared prio", 64'(busy), 0);

    // reset mid-transfer
    sw_desc_data = ptr(64'h80, 16'd1); sw_desc_valid = 1; tick(); sw_desc_valid = 0;
    rd_rsp_valid = 1; rd_rsp_data = mk(0, 0, 32'h55); tick(); rd_rsp_valid = 0;
    rst = 1; tick(); rst = 0;
    chk("R8 busy cleared", 64'(busy), 0);
    chk("R8 fetch dropped", 64'(rd_req_valid), 0);
    chk("R8 queue emptied", 64'({wr_norm_valid, wr_prio_valid}), 0);
    chk("R8 ready restored", 64'(sw_desc_ready), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule